// File: doc/BRIEF.md
# Endpoint Buffer-Ready Interrupt Flags

This block holds one sticky status flag for each of the six endpoints of a USB device controller. A flag goes high when the FIFO logic reports that the endpoint's buffer is ready for the processor. It stays high until the processor deals with that buffer on the endpoint it has selected for FIFO access. What counts as "ready" depends on the endpoint. EP0 reports only its OUT side during a control write. EP1 to EP5 report any ready buffer when the processor moves the data itself. When DMA moves the data, they report only the end of an OUT transfer that closed with a short packet.

The flags are read as the low six bits of a 16-bit status word. The upper ten bits read as zero. A single interrupt request is raised when any flag is high and its bit is set in an enable mask. Register writes from the processor never alter the flags. The flags change only through the hardware set and clear events. When a set and a clear reach the same flag in the same cycle, the set wins. All set and clear inputs are sampled on the rising clock edge, and the status word shows the new value one cycle after the event.

Top module: `ep_rdy_flags`

## Requirements
- R1: After reset the status word is 0x0000 and the interrupt request is 0. Bits 15:6 of the status word always read 0.
- R2: The EP0 flag (bit 0) sets when `ep0_out_rdy` pulses while `ep0_ctl_wr` is 1, and at least one of these holds: `ep0_cont_rx` is 1, `ep0_rx_cnt` equals 255, or `ep0_rx_short` is 1.
- R3: The EP0 flag is not set by `ep0_in_rdy`. It is also not set by `ep0_out_rdy` when `ep0_ctl_wr` is 0 or when none of the three R2 qualifiers holds.
- R4: For EP1 to EP5 with `ep_dma[i]`=0, the flag at bit i sets on a pulse of `ep_buf_rdy[i]` or of `ep_cfg_in[i]`.
- R5: For EP1 to EP5 with `ep_dma[i]`=1 and `ep_dir_in[i]`=0 (OUT), the flag sets only on a `ep_dma_done[i]` pulse that comes with or after an `ep_short_rx[i]` pulse. The remembered short packet is dropped by every `ep_dma_done[i]` pulse. `ep_buf_rdy[i]` and `ep_cfg_in[i]` have no effect in this mode.
- R6: For EP1 to EP5 with `ep_dma[i]`=1 and `ep_dir_in[i]`=1 (IN), no input sets the flag.
- R7: For an OUT endpoint (`ep_dir_in[i]`=0), the flag clears on `cmd_bclr` or `buf_rd_empty` while `fifo_sel`=i. In DMA mode only `cmd_bclr` clears it.
- R8: For an IN endpoint (`ep_dir_in[i]`=1), the flag clears on `cmd_ival` while `fifo_sel`=i. It also clears on a write-amount pulse: `buf_wr_mps` when `ep_cont_tx[i]`=0, or `buf_wr_bufsz` when `ep_cont_tx[i]`=1. The other write-amount pulse has no effect.
- R9: Clear events affect only the endpoint whose number equals `fifo_sel`. A set and a clear on the same flag in the same cycle leave the flag at 1.
- R10: `irq` is 1 exactly when some flag i is 1 with `irq_en[i]`=1.
- R11: A pulse on `reg_wr` has no effect on the flags, whatever the value of `reg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ep_dir_in | input | 6 | Per-endpoint direction, 1 = IN |
| ep_dma | input | 5 | DMA access mode for EP1..EP5 (bit 0 = EP1) |
| ep_cont_tx | input | 6 | Continuous-transmit mode per endpoint |
| ep0_ctl_wr | input | 1 | EP0 is in a control write transfer |
| ep0_cont_rx | input | 1 | EP0 continuous-receive mode |
| ep0_rx_cnt | input | 8 | Bytes received in the current EP0 OUT stage |
| ep0_rx_short | input | 1 | Last EP0 OUT packet was short |
| ep0_out_rdy | input | 1 | Pulse: EP0 OUT buffer became readable |
| ep0_in_rdy | input | 1 | Pulse: EP0 IN buffer became writable |
| ep_buf_rdy | input | 5 | Pulse: EP1..EP5 buffer became ready |
| ep_cfg_in | input | 5 | Pulse: EP1..EP5 direction configured as IN |
| ep_short_rx | input | 5 | Pulse: EP1..EP5 short packet received |
| ep_dma_done | input | 5 | Pulse: EP1..EP5 DMA transfer completed |
| fifo_sel | input | 3 | Endpoint selected for FIFO access |
| cmd_bclr | input | 1 | Pulse: buffer-clear command |
| cmd_ival | input | 1 | Pulse: buffer-valid command |
| buf_rd_empty | input | 1 | Pulse: all data read from selected buffer |
| buf_wr_mps | input | 1 | Pulse: max-packet-size written to selected buffer |
| buf_wr_bufsz | input | 1 | Pulse: full buffer size written to selected buffer |
| reg_wr | input | 1 | Processor write strobe to the status word |
| reg_wdata | input | 16 | Processor write data |
| irq_en | input | 6 | Per-endpoint interrupt enable |
| status | output | 16 | Status word, flags in bits 5:0 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a DMA OUT endpoint whose short packet is remembered, waiting for the end of its DMA transfer. The pending state is invisible at the ports, so it can only be inferred from when the flag later appears. The stimulus reaches it by pulsing the short-packet input alone and checking that the flag stays low. It then pulses DMA completion on a later cycle, and separately drops the pending state with a completion that has no short packet. A random phase mixes all strobes, modes and selections and compares against a behavioural model on every clock. In that phase, set and clear often land on the same cycle.

// File: rtl/ep_rdy_pkg.sv
package ep_rdy_pkg;

  // EP0 OUT readiness is reported only for these three causes
  function automatic logic ep0_rx_qualified(input logic cont_rx,
                                            input logic cnt_full,
                                            input logic short_pkt);
    return cont_rx | cnt_full | short_pkt;
  endfunction

  // Clear decision for one endpoint that is selected
  function automatic logic clear_hit(input logic dir_in, input logic dma,
                                     input logic cont_tx, input logic bclr,
                                     input logic ival, input logic rd_empty,
                                     input logic wr_mps, input logic wr_bufsz);
    logic wr_amount;
    wr_amount = cont_tx ? wr_bufsz : wr_mps;
    if (dir_in) return ival | wr_amount;
    if (dma)    return bclr;
    return bclr | rd_empty;
  endfunction

endpackage

// File: rtl/ep_rdy_set.sv
module ep_rdy_set #(
  parameter int NUM_EP    = 6,
  parameter int CNT_W     = 8,
  parameter int EP0_FULL  = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic [NUM_EP-1:1] ep_dma,
  input  logic              ep0_ctl_wr,
  input  logic              ep0_cont_rx,
  input  logic [CNT_W-1:0]  ep0_rx_cnt,
  input  logic              ep0_rx_short,
  input  logic              ep0_out_rdy,
  input  logic              ep0_in_rdy,
  input  logic [NUM_EP-1:1] ep_buf_rdy,
  input  logic [NUM_EP-1:1] ep_cfg_in,
  input  logic [NUM_EP-1:1] ep_short_rx,
  input  logic [NUM_EP-1:1] ep_dma_done,
  output logic [NUM_EP-1:0] set_vec
);
  import ep_rdy_pkg::*;

  logic              ep0_cnt_full;
  logic [NUM_EP-1:1] short_pend;

  assign ep0_cnt_full = (ep0_rx_cnt == CNT_W'(EP0_FULL));
  assign set_vec[0]   = ep0_out_rdy & ep0_ctl_wr &
                        ep0_rx_qualified(ep0_cont_rx, ep0_cnt_full, ep0_rx_short);

  for (genvar i = 1; i < NUM_EP; i++) begin : g_ep
    logic dma_set, cpu_set;
    assign cpu_set = ep_buf_rdy[i] | ep_cfg_in[i];
    assign dma_set = ~ep_dir_in[i] & ep_dma_done[i] & (short_pend[i] | ep_short_rx[i]);
    assign set_vec[i] = ep_dma[i] ? dma_set : cpu_set;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              short_pend[i] <= 1'b0;
      else if (ep_dma_done[i]) short_pend[i] <= 1'b0;
      else if (ep_short_rx[i]) short_pend[i] <= 1'b1;
    end

    p_dma_in_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_dma[i] && ep_dir_in[i]) |-> !set_vec[i]);
    p_dma_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_dma[i] && set_vec[i]) |-> ep_dma_done[i]);
  end

  p_ep0_in_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ep0_in_rdy && !ep0_out_rdy) |-> !set_vec[0]);
  p_ep0_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |-> (ep0_ctl_wr && ep0_out_rdy));

endmodule

// File: rtl/ep_rdy_clr.sv
module ep_rdy_clr #(
  parameter int NUM_EP = 6,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic [NUM_EP-1:1] ep_dma,
  input  logic [NUM_EP-1:0] ep_cont_tx,
  input  logic [SEL_W-1:0]  fifo_sel,
  input  logic              cmd_bclr,
  input  logic              cmd_ival,
  input  logic              buf_rd_empty,
  input  logic              buf_wr_mps,
  input  logic              buf_wr_bufsz,
  output logic [NUM_EP-1:0] clr_vec
);
  import ep_rdy_pkg::*;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic picked, dma_mode;
    assign picked = (fifo_sel == SEL_W'(i));
    if (i == 0) begin : g_ctl
      assign dma_mode = 1'b0;
    end else begin : g_data
      assign dma_mode = ep_dma[i];
    end
    assign clr_vec[i] = picked & clear_hit(ep_dir_in[i], dma_mode, ep_cont_tx[i],
                                           cmd_bclr, cmd_ival, buf_rd_empty,
                                           buf_wr_mps, buf_wr_bufsz);

    p_clr_only_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[i] |-> (fifo_sel == SEL_W'(i)));
    p_dma_out_bclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && dma_mode && !ep_dir_in[i]) |-> cmd_bclr);
  end

endmodule

// File: rtl/ep_rdy_flags.sv
module ep_rdy_flags #(
  parameter int NUM_EP   = 6,
  parameter int STAT_W   = 16,
  parameter int CNT_W    = 8,
  parameter int EP0_FULL = 255,
  localparam int SEL_W   = $clog2(NUM_EP),
  localparam int RSV_W   = STAT_W - NUM_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic [NUM_EP-1:1] ep_dma,
  input  logic [NUM_EP-1:0] ep_cont_tx,
  input  logic              ep0_ctl_wr,
  input  logic              ep0_cont_rx,
  input  logic [CNT_W-1:0]  ep0_rx_cnt,
  input  logic              ep0_rx_short,
  input  logic              ep0_out_rdy,
  input  logic              ep0_in_rdy,
  input  logic [NUM_EP-1:1] ep_buf_rdy,
  input  logic [NUM_EP-1:1] ep_cfg_in,
  input  logic [NUM_EP-1:1] ep_short_rx,
  input  logic [NUM_EP-1:1] ep_dma_done,
  input  logic [SEL_W-1:0]  fifo_sel,
  input  logic              cmd_bclr,
  input  logic              cmd_ival,
  input  logic              buf_rd_empty,
  input  logic              buf_wr_mps,
  input  logic              buf_wr_bufsz,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic [NUM_EP-1:0] irq_en,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  logic [NUM_EP-1:0] set_vec;
  logic [NUM_EP-1:0] clr_vec;
  logic [NUM_EP-1:0] flags;

  ep_rdy_set #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .EP0_FULL(EP0_FULL)) u_set (
    .clk(clk), .rst_n(rst_n), .ep_dir_in(ep_dir_in), .ep_dma(ep_dma),
    .ep0_ctl_wr(ep0_ctl_wr), .ep0_cont_rx(ep0_cont_rx), .ep0_rx_cnt(ep0_rx_cnt),
    .ep0_rx_short(ep0_rx_short), .ep0_out_rdy(ep0_out_rdy), .ep0_in_rdy(ep0_in_rdy),
    .ep_buf_rdy(ep_buf_rdy), .ep_cfg_in(ep_cfg_in), .ep_short_rx(ep_short_rx),
    .ep_dma_done(ep_dma_done), .set_vec(set_vec)
  );

  ep_rdy_clr #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) u_clr (
    .clk(clk), .rst_n(rst_n), .ep_dir_in(ep_dir_in), .ep_dma(ep_dma),
    .ep_cont_tx(ep_cont_tx), .fifo_sel(fifo_sel), .cmd_bclr(cmd_bclr),
    .cmd_ival(cmd_ival), .buf_rd_empty(buf_rd_empty), .buf_wr_mps(buf_wr_mps),
    .buf_wr_bufsz(buf_wr_bufsz), .clr_vec(clr_vec)
  );

  // Set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_vec | (flags & ~clr_vec);
  end

  assign status = {{RSV_W{1'b0}}, flags};
  assign irq    = |(flags & irq_en);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);
    p_fall_needs_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(clr_vec[i]));
  end

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));
  p_wr_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_wdata != '0) && !(|set_vec) && !(|clr_vec)) |=> $stable(flags));

endmodule

// File: tb/ep_rdy_flags_tb.sv
module ep_rdy_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ep_dir_in, ep_cont_tx, irq_en;
  logic [5:1] ep_dma, ep_buf_rdy, ep_cfg_in, ep_short_rx, ep_dma_done;
  logic ep0_ctl_wr, ep0_cont_rx, ep0_rx_short, ep0_out_rdy, ep0_in_rdy;
  logic [7:0] ep0_rx_cnt;
  logic [2:0] fifo_sel;
  logic cmd_bclr, cmd_ival, buf_rd_empty, buf_wr_mps, buf_wr_bufsz, reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] status;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [5:0] m_flag;
  logic [5:1] m_pend;

  always #2 clk = ~clk;

  ep_rdy_flags u_dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = '0;
      m_pend = '0;
    end else begin
      logic [5:0] nxt;
      nxt = m_flag;
      for (int e = 0; e < 6; e++) begin
        bit s, c, is_dma;
        is_dma = (e != 0) && ep_dma[e];
        if (e == 0)
          s = ep0_out_rdy && ep0_ctl_wr && (ep0_cont_rx || ep0_rx_cnt == 8'd255 || ep0_rx_short);
        else if (!is_dma)
          s = ep_buf_rdy[e] || ep_cfg_in[e];
        else
          s = !ep_dir_in[e] && ep_dma_done[e] && (m_pend[e] || ep_short_rx[e]);
        c = 0;
        if (fifo_sel == e) begin
          if (ep_dir_in[e])
            c = cmd_ival || (ep_cont_tx[e] ? buf_wr_bufsz : buf_wr_mps);
          else
            c = cmd_bclr || (!is_dma && buf_rd_empty);
        end
        if (s) nxt[e] = 1'b1;
        else if (c) nxt[e] = 1'b0;
      end
      for (int e = 1; e < 6; e++)
        if (ep_dma_done[e]) m_pend[e] = 1'b0;
        else if (ep_short_rx[e]) m_pend[e] = 1'b1;
      m_flag = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, status, {10'd0, m_flag});
      chk("R10", {15'd0, irq}, {15'd0, |(m_flag & irq_en)});
    end
  end

  task automatic clr_strobes();
    ep0_out_rdy = 0; ep0_in_rdy = 0; ep_buf_rdy = '0; ep_cfg_in = '0;
    ep_short_rx = '0; ep_dma_done = '0; cmd_bclr = 0; cmd_ival = 0;
    buf_rd_empty = 0; buf_wr_mps = 0; buf_wr_bufsz = 0; reg_wr = 0;
  endtask

  // Called just after a negedge with strobes set; returns one cycle later
  task automatic tick();
    @(negedge clk);
    clr_strobes();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr_strobes();
    ep_dir_in = '0; ep_cont_tx = '0; irq_en = '0; ep_dma = '0;
    ep0_ctl_wr = 0; ep0_cont_rx = 0; ep0_rx_cnt = '0; ep0_rx_short = 0;
    fifo_sel = 3'd7; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", status, 16'h0000);
    chk("R1", {15'd0, irq}, 16'h0000);

    cur_req = "R11";
    reg_wr = 1; reg_wdata = 16'hFFFF; tick();
    chk("R11", status, 16'h0000);

    cur_req = "R3";
    ep0_ctl_wr = 1; ep0_in_rdy = 1; tick();
    ep0_rx_cnt = 8'd10; ep0_out_rdy = 1; tick();
    chk("R3", status, 16'h0000);
    ep0_ctl_wr = 0; ep0_cont_rx = 1; ep0_out_rdy = 1; tick();
    chk("R3", status, 16'h0000);

    cur_req = "R2";
    ep0_cont_rx = 0; ep0_ctl_wr = 1; ep0_rx_cnt = 8'd255; ep0_out_rdy = 1; tick();
    chk("R2", status, 16'h0001);
    cur_req = "R7";
    fifo_sel = 3'd0; buf_rd_empty = 1; tick();
    chk("R7", status, 16'h0000);
    cur_req = "R2";
    ep0_rx_cnt = 8'd3; ep0_rx_short = 1; ep0_out_rdy = 1; tick();
    chk("R2", status, 16'h0001);
    cur_req = "R7";
    cmd_bclr = 1; tick();
    chk("R7", status, 16'h0000);
    cur_req = "R2";
    ep0_rx_short = 0; ep0_cont_rx = 1; ep0_out_rdy = 1; tick();
    chk("R2", status, 16'h0001);
    cmd_bclr = 1; tick();
    ep0_cont_rx = 0; ep0_ctl_wr = 0;

    cur_req = "R4";
    ep_buf_rdy[1] = 1; ep_cfg_in[2] = 1; tick();
    chk("R4", status, 16'h0006);
    irq_en = 6'h00; @(negedge clk); chk("R10", {15'd0, irq}, 16'h0000);
    irq_en = 6'h04; @(negedge clk); chk("R10", {15'd0, irq}, 16'h0001);
    irq_en = 6'h01; @(negedge clk); chk("R10", {15'd0, irq}, 16'h0000);
    irq_en = 6'h3F;

    cur_req = "R9";
    fifo_sel = 3'd1; buf_rd_empty = 1; tick();
    chk("R9", status, 16'h0004);
    ep_dir_in[2] = 1; fifo_sel = 3'd2; cmd_ival = 1; ep_cfg_in[2] = 1; tick();
    chk("R9", status, 16'h0004);
    cur_req = "R8";
    cmd_ival = 1; tick();
    chk("R8", status, 16'h0000);

    ep_dir_in[3] = 1; ep_buf_rdy[3] = 1; tick();
    fifo_sel = 3'd3; buf_wr_bufsz = 1; tick();
    chk("R8", status, 16'h0008);
    buf_wr_mps = 1; tick();
    chk("R8", status, 16'h0000);
    ep_cont_tx[3] = 1; ep_buf_rdy[3] = 1; tick();
    buf_wr_mps = 1; tick();
    chk("R8", status, 16'h0008);
    buf_wr_bufsz = 1; tick();
    chk("R8", status, 16'h0000);

    cur_req = "R5";
    ep_dma[4] = 1; fifo_sel = 3'd4;
    ep_buf_rdy[4] = 1; ep_cfg_in[4] = 1; tick();
    ep_dma_done[4] = 1; tick();
    ep_short_rx[4] = 1; tick();
    chk("R5", status, 16'h0000);
    ep_dma_done[4] = 1; tick();
    chk("R5", status, 16'h0010);
    cur_req = "R7";
    buf_rd_empty = 1; tick();
    chk("R7", status, 16'h0010);
    cmd_bclr = 1; tick();
    chk("R7", status, 16'h0000);
    cur_req = "R5";
    ep_dma_done[4] = 1; tick();
    chk("R5", status, 16'h0000);

    cur_req = "R6";
    ep_dma[5] = 1; ep_dir_in[5] = 1;
    ep_buf_rdy[5] = 1; ep_cfg_in[5] = 1; ep_short_rx[5] = 1; tick();
    ep_dma_done[5] = 1; tick();
    chk("R6", status, 16'h0000);

    cur_req = "R9";
    for (int n = 0; n < 2000; n++) begin
      if (n % 64 == 0) begin
        ep_dir_in = 6'($urandom); ep_dma = 5'($urandom); ep_cont_tx = 6'($urandom);
        ep0_ctl_wr = 1'($urandom); ep0_cont_rx = 1'($urandom);
      end
      ep0_rx_cnt = ($urandom % 4 == 0) ? 8'd255 : 8'($urandom);
      ep0_rx_short = 1'($urandom); irq_en = 6'($urandom);
      fifo_sel = 3'($urandom);
      ep0_out_rdy = ($urandom % 4 == 0); ep0_in_rdy = 1'($urandom);
      ep_buf_rdy = 5'($urandom) & 5'($urandom);
      ep_cfg_in = 5'($urandom) & 5'($urandom) & 5'($urandom);
      ep_short_rx = 5'($urandom) & 5'($urandom);
      ep_dma_done = 5'($urandom) & 5'($urandom);
      cmd_bclr = ($urandom % 5 == 0); cmd_ival = ($urandom % 5 == 0);
      buf_rd_empty = ($urandom % 4 == 0); buf_wr_mps = ($urandom % 4 == 0);
      buf_wr_bufsz = ($urandom % 4 == 0);
      reg_wr = 1'($urandom); reg_wdata = 16'($urandom);
      tick();
    end
    finish_run();
  end
endmodule